// File: doc/BRIEF.md
# Keyboard-Controller-Style Host Mailbox with Maintenance Command Engine

This block is the controller-side half of a classic two-port keyboard-controller host mailbox. A host reaches it through two byte-wide ports. The data port sits at I/O address 0x60 and the command/status port at 0x64; the port select input carries the one address bit that tells them apart. Each direction has exactly one byte of buffering. A status byte reports whether the input buffer is still occupied and whether a reply is waiting. It also keeps a sticky flag for writes that were dropped because the input buffer was full.

An internal command engine takes a fixed, parameterised number of cycles to consume each byte the host writes. It then decodes two maintenance opcodes that arrive through the command port. One opcode moves the controller into a scratch-RAM update mode and posts an acknowledge byte. The other opcode returns the controller to normal execution. If that second opcode arrives when the controller is already in normal mode, it raises a one-cycle reset request instead. Everything else is consumed silently.

Top module: `kbc_mailbox`

## Requirements
- R1: After a synchronous reset, the status byte reads 0x00, `update_mode` and `reset_req` are 0, and `host_rdata` is 0x00.
- R2: A read with `host_sel`=1 places the status byte on `host_rdata` from the next cycle. In the status byte, bit 0 is output-full, bit 1 is input-full and bit 7 is overrun; all other bits read 0. `host_rdata` changes only after a read.
- R3: A write on either port while the input buffer is empty stores the byte, and input-full reads 1 from the next cycle. Input-full stays 1 for exactly CONSUME_CYC cycles and then returns to 0.
- R4: A write while input-full is 1 is dropped: the stored byte is unchanged and the dropped byte has no effect. The write also sets the overrun bit. A status read clears overrun, but a drop in the same cycle as that read leaves it set.
- R5: When the byte 0xB4 written through the command port is consumed, `update_mode` goes to 1, the output buffer takes 0xFA, and output-full goes to 1.
- R6: When the byte 0xFE written through the command port is consumed in update mode, `update_mode` returns to 0. No reply is posted and no reset request is raised.
- R7: When the byte 0xFE written through the command port is consumed in normal mode, `reset_req` is 1 for exactly one cycle and `update_mode` stays 0.
- R8: A read with `host_sel`=0 returns the output buffer byte on `host_rdata` from the next cycle and clears output-full.
- R9: Any other command-port byte, and any byte at all written through the data port (0xB4 and 0xFE included), is consumed with no reply, no mode change and no reset request.
- R10: If a reply is posted in the same cycle as a data-port read, the read returns the previous buffer content and output-full is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_sel | input | 1 | Port select: 0 = data port (0x60), 1 = command/status port (0x64) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte: status or output buffer |
| update_mode | output | 1 | 1 while the controller is in scratch-RAM update mode |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with CONSUME_CYC=3. This is short enough that random traffic often lands a second write inside the busy window, which exercises the drop and overrun path. It also lets a data-port read be placed on the exact cycle a reply is posted. The same value still checks that input-full stays high for more than one cycle with a non-default length. Random traffic favours the two maintenance opcodes, so that both mode changes and the normal-mode reset pulse occur repeatedly.

// File: rtl/kbc_mbx_pkg.sv
package kbc_mbx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_ENTER_UPD = 8'hB4;
  localparam logic [BYTE_W-1:0] OP_LEAVE_UPD = 8'hFE;
  localparam logic [BYTE_W-1:0] ACK_BYTE     = 8'hFA;
  localparam int ST_OBF_BIT = 0;
  localparam int ST_IBF_BIT = 1;
  localparam int ST_OVR_BIT = 7;
endpackage

// File: rtl/kbc_mbx_inbuf.sv
module kbc_mbx_inbuf
  import kbc_mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              stat_rd,
  input  logic              take,
  output logic              full,
  output logic              is_cmd,
  output logic [BYTE_W-1:0] byte_q,
  output logic              ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      is_cmd <= 1'b0;
      byte_q <= '0;
      ovr    <= 1'b0;
    end else begin
      if (take) full <= 1'b0;
      if (wr && !full) begin
        full   <= 1'b1;
        is_cmd <= sel;
        byte_q <= wdata;
      end
      if (wr && full) ovr <= 1'b1;
      else if (stat_rd) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_mbx_engine.sv
module kbc_mbx_engine
  import kbc_mbx_pkg::*;
#(
  parameter int CONSUME_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full,
  input  logic              is_cmd,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              take,
  output logic              post,
  output logic [BYTE_W-1:0] post_data,
  output logic              update_mode,
  output logic              reset_req
);
  localparam int CNT_W = (CONSUME_CYC > 1) ? $clog2(CONSUME_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONSUME_CYC - 1);

  generate
    if (CONSUME_CYC > 1) begin : g_timer
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !full) cnt <= '0;
        else if (cnt == CNT_LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign take = full && (cnt == CNT_LAST);
    end else begin : g_single
      assign take = full;
    end
  endgenerate

  logic is_enter, is_leave;
  assign is_enter = take && is_cmd && (byte_q == OP_ENTER_UPD);
  assign is_leave = take && is_cmd && (byte_q == OP_LEAVE_UPD);
  assign post      = is_enter;
  assign post_data = ACK_BYTE;

  always_ff @(posedge clk) begin
    if (rst) begin
      update_mode <= 1'b0;
      reset_req   <= 1'b0;
    end else begin
      reset_req <= is_leave && !update_mode;
      if (is_enter) update_mode <= 1'b1;
      else if (is_leave) update_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_mbx_outbuf.sv
module kbc_mbx_outbuf
  import kbc_mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              post,
  input  logic [BYTE_W-1:0] post_data,
  input  logic              rd,
  input  logic              sel,
  input  logic [BYTE_W-1:0] status,
  output logic              obf,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] obuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      obf   <= 1'b0;
      obuf  <= '0;
      rdata <= '0;
    end else begin
      if (rd) rdata <= sel ? status : obuf;
      if (post) begin
        obf  <= 1'b1;
        obuf <= post_data;
      end else if (rd && !sel) begin
        obf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_mbx_pkg::*;
#(
  parameter int CONSUME_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              update_mode,
  output logic              reset_req
);
  logic              ibf_q, obf_q, ovr_q, is_cmd, take, post;
  logic [BYTE_W-1:0] in_byte, post_data, status;

  always_comb begin
    status             = '0;
    status[ST_OBF_BIT] = obf_q;
    status[ST_IBF_BIT] = ibf_q;
    status[ST_OVR_BIT] = ovr_q;
  end

  kbc_mbx_inbuf u_inbuf (
    .clk(clk), .rst(rst), .wr(host_wr), .sel(host_sel), .wdata(host_wdata),
    .stat_rd(host_rd && host_sel), .take(take), .full(ibf_q),
    .is_cmd(is_cmd), .byte_q(in_byte), .ovr(ovr_q)
  );

  kbc_mbx_engine #(.CONSUME_CYC(CONSUME_CYC)) u_engine (
    .clk(clk), .rst(rst), .full(ibf_q), .is_cmd(is_cmd), .byte_q(in_byte),
    .take(take), .post(post), .post_data(post_data),
    .update_mode(update_mode), .reset_req(reset_req)
  );

  kbc_mbx_outbuf u_outbuf (
    .clk(clk), .rst(rst), .post(post), .post_data(post_data),
    .rd(host_rd), .sel(host_sel), .status(status),
    .obf(obf_q), .rdata(host_rdata)
  );
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk #(
  parameter int CONSUME_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] host_rdata,
  input logic       update_mode,
  input logic       reset_req,
  input logic       ibf_q,
  input logic       obf_q,
  input logic       ovr_q
);
  logic [15:0] hcnt;
  always_ff @(posedge clk) begin
    if (rst || !ibf_q) hcnt <= '0;
    else if (hcnt != 16'hFFFF) hcnt <= hcnt + 1'b1;
  end

  AST_IBF_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    host_wr && !ibf_q |=> ibf_q); // R3
  AST_IBF_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(ibf_q) |-> hcnt == 16'(CONSUME_CYC)); // R3
  AST_IBF_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
    hcnt <= 16'(CONSUME_CYC)); // R3
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (rst)
    host_wr && ibf_q |=> ovr_q); // R4
  AST_ENTER_POSTS: assert property (@(posedge clk) disable iff (rst)
    $rose(update_mode) |-> obf_q); // R5
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req); // R7
  AST_RESET_NORMAL_MODE: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> !update_mode); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata)); // R2
endmodule

bind kbc_mailbox kbc_mailbox_chk #(.CONSUME_CYC(CONSUME_CYC)) chk_i (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_rdata(host_rdata), .update_mode(update_mode), .reset_req(reset_req),
  .ibf_q(ibf_q), .obf_q(obf_q), .ovr_q(ovr_q)
);

// File: tb/kbc_mailbox_tb_top.sv
module kbc_mailbox_tb_top;
  localparam int C = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       update_mode, reset_req;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  kbc_mailbox #(.CONSUME_CYC(C)) dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .update_mode(update_mode), .reset_req(reset_req)
  );

  // Reference model built from the requirements
  logic       m_ibf, m_obf, m_ovr, m_cmd, m_mode, m_rst;
  logic [7:0] m_byte, m_out, m_rdata;
  int         m_cnt;

  function automatic logic [7:0] m_status(logic ovr, logic ibf, logic obf);
    return {ovr, 5'b0, ibf, obf};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ibf = 0; m_obf = 0; m_ovr = 0; m_cmd = 0; m_mode = 0; m_rst = 0;
      m_byte = 0; m_out = 0; m_rdata = 0; m_cnt = 0;
    end else begin
      logic n_ibf, n_obf, n_ovr, n_mode, n_rst;
      logic [7:0] n_out;
      n_ibf = m_ibf; n_obf = m_obf; n_ovr = m_ovr; n_mode = m_mode;
      n_rst = 0; n_out = m_out;
      if (host_rd) m_rdata = host_sel ? m_status(m_ovr, m_ibf, m_obf) : m_out;
      if (host_rd && !host_sel) n_obf = 0;
      if (host_rd && host_sel) n_ovr = 0;
      if (host_wr && m_ibf) n_ovr = 1;
      if (m_ibf && m_cnt == C - 1) begin
        n_ibf = 0; m_cnt = 0;
        if (m_cmd && m_byte == 8'hB4) begin n_mode = 1; n_out = 8'hFA; n_obf = 1; end
        else if (m_cmd && m_byte == 8'hFE) begin
          if (m_mode) n_mode = 0; else n_rst = 1;
        end
      end else if (m_ibf) m_cnt++;
      if (host_wr && !m_ibf) begin
        n_ibf = 1; m_byte = host_wdata; m_cmd = host_sel; m_cnt = 0;
      end
      m_ibf = n_ibf; m_obf = n_obf; m_ovr = n_ovr; m_mode = n_mode;
      m_rst = n_rst; m_out = n_out;
    end
  end

  always @(negedge clk) if (!rst && reset_req) pulses++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(logic sel, logic [7:0] d);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hread(logic sel, output logic [7:0] v);
    host_rd = 1; host_sel = sel;
    @(negedge clk);
    host_rd = 0;
    v = host_rdata;
  endtask

  task automatic run_all();
    logic [7:0] v;
    int p0;
    idle(3); rst = 0; idle(1);
    check("R1 rdata after reset", host_rdata, 8'h00);
    check("R1 update_mode after reset", update_mode, 0);
    check("R1 reset_req after reset", reset_req, 0);
    hread(1, v); check("R1 status after reset", v, 8'h00);

    hwrite(1, 8'hB4);
    hread(1, v); check("R3 input-full set after write", v, 8'h02);
    idle(2);
    hread(1, v); check("R3 input-full clear after window", v, 8'h01);
    check("R5 update_mode after enter", update_mode, 1);
    hread(0, v); check("R8 ack byte", v, 8'hFA);
    check("R5 ack value", v, 8'hFA);
    hread(1, v); check("R8 output-full cleared by read", v, 8'h00);

    p0 = pulses;
    hwrite(1, 8'hFE);
    hwrite(0, 8'h55);
    hread(1, v); check("R4 overrun bit", v, 8'h82);
    hread(1, v); check("R4 overrun cleared by status read", v, 8'h02);
    idle(2);
    hread(1, v); check("R6 no reply after leave, R4 dropped byte unused", v, 8'h00);
    check("R6 update_mode after leave", update_mode, 0);
    check("R6 no reset in update mode", pulses - p0, 0);

    p0 = pulses;
    hwrite(1, 8'hFE);
    idle(6);
    check("R7 one reset pulse", pulses - p0, 1);
    check("R7 mode stays normal", update_mode, 0);

    p0 = pulses;
    hwrite(1, 8'h12); idle(4);
    hread(1, v); check("R9 unknown opcode no reply", v, 8'h00);
    hwrite(0, 8'hB4); idle(4);
    check("R9 data-port B4 no mode", update_mode, 0);
    hwrite(0, 8'hFE); idle(4);
    hread(1, v); check("R9 data-port bytes no reply", v, 8'h00);
    check("R9 no reset from data port", pulses - p0, 0);

    hwrite(1, 8'hB4); idle(2);
    hread(0, v); check("R10 read during post returns old byte", v, 8'hFA);
    hread(1, v); check("R10 output-full kept by post", v, 8'h01);
    hread(0, v); check("R8 second ack", v, 8'hFA);
    hwrite(1, 8'hFE); idle(4);
    check("R6 leave again", update_mode, 0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      check("R2 random rdata", host_rdata, m_rdata);
      check("R5 random update_mode", update_mode, m_mode);
      check("R7 random reset_req", reset_req, m_rst);
      r = int'($urandom % 8);
      host_wr = ($urandom % 3) == 0;
      host_rd = ($urandom % 3) == 0;
      host_sel = ($urandom % 4) != 0;
      host_wdata = (r < 3) ? 8'hB4 : (r < 5) ? 8'hFE : 8'($urandom);
      @(negedge clk);
    end
    host_wr = 0; host_rd = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule